// File: doc/BRIEF.md
# Digital Potentiometer Command Slave on a Two-Wire Bus

This block is the command side of an 8-bit digitally controlled resistor, reached over an I2C bus. It watches the open-drain clock and data lines through synchronisers clocked by the system clock. It recognises START and STOP conditions and takes bytes MSB first. It acknowledges only when the 7-bit address on the bus equals the `dev_addr` input. In the first byte after the address, the top three bits form a command. A command either points the block at one register or starts a copy between the wiper and its nonvolatile mirror.

The selectable registers are the live wiper, the nonvolatile mirror, a write-protect flag and two read-only bytes of factory resistance tolerance. The wiper drives the resistor array. The mirror holds a copy of what the nonvolatile memory stores. Each change to the mirror sends a one-cycle request, carrying the new byte, to an external storage controller. That controller reports back through a busy level. The pointer is kept between transactions, so a read can start directly with the read address when the wanted register was the last one selected.

Top module: `dpot_i2c_slave`

## Requirements
- R1: After reset the wiper holds 0x80, the data line is released (`sda_oe` = 0), write protect is off and no storage request is raised.
- R2: The block pulls the data line low during the ninth clock only when address bits [7:1] of the first byte after START equal `dev_addr`. Bit 0 of that byte selects read when 1. With any other address the block gives no acknowledge and ignores all later bytes until the next START, so the wiper keeps its value.
- R3: A write transaction with instruction 0x00 (command bits [7:5] = 000) loads each following data byte into the wiper as soon as that byte completes, until STOP. Every data byte is acknowledged.
- R4: In a read, the selected register is shifted out MSB first, and the data line changes only while SCL is low. A master acknowledge after a byte produces another byte from the pointer. A master NACK releases the line. A read that skips the pointer-setting bytes returns the register selected last.
- R5: Instruction 0x20 (command 001, low five bits not a tolerance location) selects the mirror. A data byte written to it updates the mirror and raises `nv_req` for exactly one cycle, with `nv_data` equal to the new byte. Reading the mirror returns that byte.
- R6: Instruction 0x40 (command 010) selects write protect. Bit 0 of the data byte sets protect when 1 and clears it when 0; the other bits have no effect. Reading it returns 0000000 followed by the protect bit.
- R7: While protect is set, a mirror write or a store command is acknowledged but leaves the mirror unchanged and raises no `nv_req`.
- R8: Instruction 0xC0 (command 110, no data byte) copies the wiper into the mirror and raises `nv_req`. Instruction 0xA0 (command 101, no data byte) copies the mirror into the wiper.
- R9: Instruction 0x3E (command 001, location 11110) selects the sign-and-integer tolerance byte (0x1C by default). Instruction 0x3F (location 11111) selects the fraction byte (0x0F by default). When the master acknowledges a byte read from 11110, the pointer moves to 11111, and it stays there for further acknowledged reads.
- R10: Data bytes written to a tolerance location are acknowledged but ignored, so a later readback returns the factory value.
- R11: While `nv_busy` is high, mirror writes, store commands and restore commands are acknowledged and discarded: no `nv_req`, and neither the mirror nor the wiper changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed at the pad |
| sda_i | input | 1 | Bus data line as sensed at the pad |
| sda_oe | output | 1 | When 1, the pad pulls the data line low |
| dev_addr | input | 7 | Bus address this instance answers to |
| wiper | output | 8 | Current wiper position |
| nv_busy | input | 1 | Storage controller is busy writing |
| nv_req | output | 1 | One-cycle request to store `nv_data` |
| nv_data | output | 8 | Mirror value to be stored |

## Verification
The checks assume that SCL and SDA hold each level for several system clocks, more than the synchroniser and edge-detect latency. They also assume that SDA changes only while SCL is low, except at intended START and STOP conditions, and that the master never signals START or STOP while the slave holds the line low. The bench bit-bangs the bus with eight-clock phases. It changes SDA only in the middle of a low SCL phase and releases the line before every acknowledge slot, so all inputs stay inside these assumptions. `nv_busy` is driven as a steady level around whole transactions.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
   typedef enum logic [2:0] {
      PTR_RDAC,
      PTR_EEP,
      PTR_WP,
      PTR_TOL_HI,
      PTR_TOL_LO
   } ptr_e;

   typedef enum logic [2:0] {
      BS_IDLE,
      BS_ADDR,
      BS_ADDR_ACK,
      BS_RX,
      BS_RX_ACK,
      BS_TX,
      BS_TX_ACK
   } bstate_e;

   localparam logic [2:0] CMD_RDAC    = 3'b000;
   localparam logic [2:0] CMD_EEP     = 3'b001;
   localparam logic [2:0] CMD_WP      = 3'b010;
   localparam logic [2:0] CMD_RESTORE = 3'b101;
   localparam logic [2:0] CMD_STORE   = 3'b110;
endpackage

// File: rtl/dpot_line_sync.sv
module dpot_line_sync #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] pipe_q;
   logic              prev_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("dpot_line_sync needs at least two stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_q <= {STAGES{IDLE_LVL}};
         prev_q <= IDLE_LVL;
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], d_i};
         prev_q <= pipe_q[STAGES-1];
      end
   end

   assign q_o    = pipe_q[STAGES-1];
   assign rise_o = pipe_q[STAGES-1] & ~prev_q;
   assign fall_o = ~pipe_q[STAGES-1] & prev_q;
endmodule

// File: rtl/dpot_byte_engine.sv
module dpot_byte_engine
   import dpot_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_q,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_q,
   input  logic              bus_start,
   input  logic              bus_stop,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [BYTE_W-1:0] tx_byte,
   output logic              sda_oe,
   output logic              rx_stb,
   output logic              rx_first,
   output logic [BYTE_W-1:0] rx_byte,
   output logic              tx_next
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   if (ADDR_W + 1 != BYTE_W) begin : g_bad_addr
      $error("address plus direction bit must fill one byte");
   end

   bstate_e           state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;
   logic              oe_q;
   logic              rw_q;
   logic              first_q;
   logic              stb_q;
   logic              nxt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= BS_IDLE;
         cnt_q   <= '0;
         sh_q    <= '0;
         oe_q    <= 1'b0;
         rw_q    <= 1'b0;
         first_q <= 1'b0;
         stb_q   <= 1'b0;
         nxt_q   <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         nxt_q <= 1'b0;
         if (bus_start) begin
            state_q <= BS_ADDR;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
         end else if (bus_stop) begin
            state_q <= BS_IDLE;
            oe_q    <= 1'b0;
         end else begin
            unique case (state_q)
               BS_ADDR, BS_RX: begin
                  if (scl_rise && cnt_q < FULL) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], sda_q};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == FULL) begin
                     if (state_q == BS_ADDR) begin
                        if (sh_q[BYTE_W-1:1] == dev_addr) begin
                           oe_q    <= 1'b1;
                           rw_q    <= sh_q[0];
                           first_q <= 1'b1;
                           state_q <= BS_ADDR_ACK;
                        end else begin
                           state_q <= BS_IDLE;
                        end
                     end else begin
                        oe_q    <= 1'b1;
                        stb_q   <= 1'b1;
                        state_q <= BS_RX_ACK;
                     end
                  end
               end
               BS_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt_q <= '0;
                     if (rw_q) begin
                        sh_q    <= tx_byte;
                        oe_q    <= ~tx_byte[BYTE_W-1];
                        state_q <= BS_TX;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= BS_RX;
                     end
                  end
               end
               BS_RX_ACK: begin
                  if (scl_fall) begin
                     oe_q    <= 1'b0;
                     cnt_q   <= '0;
                     first_q <= 1'b0;
                     state_q <= BS_RX;
                  end
               end
               BS_TX: begin
                  if (scl_rise) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt_q == FULL) begin
                        oe_q    <= 1'b0;
                        state_q <= BS_TX_ACK;
                     end else begin
                        sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
                        oe_q <= ~sh_q[BYTE_W-2];
                     end
                  end
               end
               BS_TX_ACK: begin
                  if (scl_rise) begin
                     if (!sda_q) nxt_q <= 1'b1;
                     else        state_q <= BS_IDLE;
                  end else if (scl_fall) begin
                     cnt_q   <= '0;
                     sh_q    <= tx_byte;
                     oe_q    <= ~tx_byte[BYTE_W-1];
                     state_q <= BS_TX;
                  end
               end
               default: begin
                  oe_q <= 1'b0;
               end
            endcase
         end
      end
   end

   assign sda_oe   = oe_q;
   assign rx_stb   = stb_q;
   assign rx_first = first_q;
   assign rx_byte  = sh_q;
   assign tx_next  = nxt_q;

   AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(oe_q) |-> !scl_q); // R4
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BS_IDLE) |-> !oe_q); // R2
   AST_NEXT_AFTER_TX: assert property (@(posedge clk) disable iff (!rst_n)
      nxt_q |-> (state_q == BS_TX_ACK)); // R4
endmodule

// File: rtl/dpot_cmd_regs.sv
module dpot_cmd_regs
   import dpot_pkg::*;
#(
   parameter int          BYTE_W      = 8,
   parameter int          LOC_W       = 5,
   parameter logic [7:0]  WIPER_RESET = 8'h80,
   parameter logic [7:0]  EEP_RESET   = 8'h80,
   parameter logic [7:0]  TOL_INT     = 8'h1C,
   parameter logic [7:0]  TOL_FRAC    = 8'h0F,
   parameter logic [4:0]  TOL_LOC     = 5'b11110
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_stb,
   input  logic              rx_first,
   input  logic [BYTE_W-1:0] rx_byte,
   input  logic              tx_next,
   input  logic              nv_busy,
   output logic [BYTE_W-1:0] tx_byte,
   output logic [BYTE_W-1:0] wiper,
   output logic              nv_req,
   output logic [BYTE_W-1:0] nv_data
);
   localparam int CMD_W = BYTE_W - LOC_W;
   localparam logic [LOC_W-1:0] TOL_LOC_LO = TOL_LOC + 1'b1;

   if (CMD_W != 3) begin : g_bad_cmd
      $error("command field must be three bits wide");
   end
   if (TOL_LOC[0] != 1'b0) begin : g_bad_loc
      $error("tolerance base location must be even");
   end

   ptr_e              ptr_q;
   logic [BYTE_W-1:0] wiper_q;
   logic [BYTE_W-1:0] shadow_q;
   logic              wp_q;
   logic              req_q;
   logic [CMD_W-1:0]  cmd;
   logic [LOC_W-1:0]  loc;
   logic              nv_open;

   assign cmd     = rx_byte[BYTE_W-1:LOC_W];
   assign loc     = rx_byte[LOC_W-1:0];
   assign nv_open = !wp_q && !nv_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= PTR_RDAC;
         wiper_q  <= WIPER_RESET;
         shadow_q <= EEP_RESET;
         wp_q     <= 1'b0;
         req_q    <= 1'b0;
      end else begin
         req_q <= 1'b0;
         if (rx_stb && rx_first) begin
            unique case (cmd)
               CMD_RDAC: ptr_q <= PTR_RDAC;
               CMD_EEP: begin
                  if (loc == TOL_LOC)         ptr_q <= PTR_TOL_HI;
                  else if (loc == TOL_LOC_LO) ptr_q <= PTR_TOL_LO;
                  else                        ptr_q <= PTR_EEP;
               end
               CMD_WP: ptr_q <= PTR_WP;
               CMD_STORE: begin
                  if (nv_open) begin
                     shadow_q <= wiper_q;
                     req_q    <= 1'b1;
                  end
               end
               CMD_RESTORE: begin
                  if (!nv_busy) wiper_q <= shadow_q;
               end
               default: ;
            endcase
         end else if (rx_stb) begin
            unique case (ptr_q)
               PTR_RDAC: wiper_q <= rx_byte;
               PTR_EEP: begin
                  if (nv_open) begin
                     shadow_q <= rx_byte;
                     req_q    <= 1'b1;
                  end
               end
               PTR_WP:  wp_q <= rx_byte[0];
               default: ;
            endcase
         end else if (tx_next && ptr_q == PTR_TOL_HI) begin
            ptr_q <= PTR_TOL_LO;
         end
      end
   end

   always_comb begin
      unique case (ptr_q)
         PTR_RDAC:   tx_byte = wiper_q;
         PTR_EEP:    tx_byte = shadow_q;
         PTR_WP:     tx_byte = {{(BYTE_W-1){1'b0}}, wp_q};
         PTR_TOL_HI: tx_byte = TOL_INT;
         PTR_TOL_LO: tx_byte = TOL_FRAC;
         default:    tx_byte = '0;
      endcase
   end

   assign wiper   = wiper_q;
   assign nv_req  = req_q;
   assign nv_data = shadow_q;

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |=> !req_q); // R5
   AST_WP_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> !$past(wp_q)); // R7
   AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> !$past(nv_busy)); // R11
   AST_SHADOW_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(shadow_q) |-> ($past(!wp_q) && $past(!nv_busy))); // R7
   AST_TOL_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q == PTR_TOL_LO && !(rx_stb && rx_first)) |=> (ptr_q == PTR_TOL_LO)); // R9
endmodule

// File: rtl/dpot_i2c_slave.sv
module dpot_i2c_slave #(
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] WIPER_RESET = 8'h80,
   parameter logic [7:0] EEP_RESET   = 8'h80,
   parameter logic [7:0] TOL_INT     = 8'h1C,
   parameter logic [7:0] TOL_FRAC    = 8'h0F,
   parameter logic [4:0] TOL_LOC     = 5'b11110
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic [6:0] dev_addr,
   output logic [7:0] wiper,
   input  logic       nv_busy,
   output logic       nv_req,
   output logic [7:0] nv_data
);
   localparam int BYTE_W = 8;
   localparam int ADDR_W = BYTE_W - 1;
   localparam int LOC_W  = 5;
   localparam int LINES  = 2;

   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be between 2 and 4");
   end

   logic [LINES-1:0] raw_ln;
   logic [LINES-1:0] q_ln;
   logic [LINES-1:0] rise_ln;
   logic [LINES-1:0] fall_ln;

   assign raw_ln = {sda_i, scl_i};

   for (genvar g = 0; g < LINES; g++) begin : g_sync
      dpot_line_sync #(
         .STAGES   (SYNC_STAGES),
         .IDLE_LVL (1'b1)
      ) i_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .d_i    (raw_ln[g]),
         .q_o    (q_ln[g]),
         .rise_o (rise_ln[g]),
         .fall_o (fall_ln[g])
      );
   end

   logic scl_q, sda_q, bus_start, bus_stop;
   assign scl_q     = q_ln[0];
   assign sda_q     = q_ln[1];
   assign bus_start = scl_q & fall_ln[1];
   assign bus_stop  = scl_q & rise_ln[1];

   logic              rx_stb, rx_first, tx_next;
   logic [BYTE_W-1:0] rx_byte, tx_byte;

   dpot_byte_engine #(
      .ADDR_W (ADDR_W),
      .BYTE_W (BYTE_W)
   ) i_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_q     (scl_q),
      .scl_rise  (rise_ln[0]),
      .scl_fall  (fall_ln[0]),
      .sda_q     (sda_q),
      .bus_start (bus_start),
      .bus_stop  (bus_stop),
      .dev_addr  (dev_addr),
      .tx_byte   (tx_byte),
      .sda_oe    (sda_oe),
      .rx_stb    (rx_stb),
      .rx_first  (rx_first),
      .rx_byte   (rx_byte),
      .tx_next   (tx_next)
   );

   dpot_cmd_regs #(
      .BYTE_W      (BYTE_W),
      .LOC_W       (LOC_W),
      .WIPER_RESET (WIPER_RESET),
      .EEP_RESET   (EEP_RESET),
      .TOL_INT     (TOL_INT),
      .TOL_FRAC    (TOL_FRAC),
      .TOL_LOC     (TOL_LOC)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .rx_stb   (rx_stb),
      .rx_first (rx_first),
      .rx_byte  (rx_byte),
      .tx_next  (tx_next),
      .nv_busy  (nv_busy),
      .tx_byte  (tx_byte),
      .wiper    (wiper),
      .nv_req   (nv_req),
      .nv_data  (nv_data)
   );
endmodule

// File: tb/test_dpot_i2c_slave.sv
module test_dpot_i2c_slave;
   localparam logic [6:0] DEV = 7'h2C;
   localparam int PH = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       nv_busy = 1'b0;
   logic       sda_oe, nv_req;
   logic [7:0] wiper, nv_data;
   logic       sda_line;

   int checks = 0;
   int failures = 0;
   int req_cnt = 0;
   logic [7:0] req_val = 8'h00;
   bit done = 0;

   assign sda_line = sda_m & ~sda_oe;

   dpot_i2c_slave i_dpot_i2c_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_m),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .dev_addr (DEV),
      .wiper    (wiper),
      .nv_busy  (nv_busy),
      .nv_req   (nv_req),
      .nv_data  (nv_data)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      if (nv_req) begin
         req_cnt <= req_cnt + 1;
         req_val <= nv_data;
      end
   end

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(PH);
      scl_m = 1'b1; tick(PH);
      sda_m = 1'b0; tick(PH);
      scl_m = 1'b0; tick(PH);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(PH);
      scl_m = 1'b1; tick(PH);
      sda_m = 1'b1; tick(PH);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; tick(PH);
         scl_m = 1'b1; tick(PH);
         scl_m = 1'b0; tick(PH);
      end
      sda_m = 1'b1; tick(PH);
      scl_m = 1'b1; tick(PH);
      ack = ~sda_line;
      scl_m = 1'b0; tick(PH);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         tick(PH);
         scl_m = 1'b1; tick(PH);
         b[i] = sda_line;
         scl_m = 1'b0;
      end
      tick(PH);
      sda_m = ~mack; tick(PH);
      scl_m = 1'b1; tick(PH);
      scl_m = 1'b0; tick(PH);
      sda_m = 1'b1;
   endtask

   // write transaction: instruction plus n data bytes; returns AND of acks
   task automatic wr_txn(input logic [7:0] instr, input int n,
                         input logic [7:0] d0, input logic [7:0] d1,
                         output logic all_ack);
      logic a;
      bus_start();
      send_byte({DEV, 1'b0}, a); all_ack = a;
      send_byte(instr, a); all_ack &= a;
      if (n > 0) begin send_byte(d0, a); all_ack &= a; end
      if (n > 1) begin send_byte(d1, a); all_ack &= a; end
      bus_stop();
   endtask

   // read n (1..3) bytes; pointer set first when set_ptr is 1
   task automatic rd_txn(input bit set_ptr, input logic [7:0] instr, input int n,
                         output logic [7:0] r0, output logic [7:0] r1,
                         output logic [7:0] r2, output logic all_ack);
      logic a;
      all_ack = 1'b1;
      r1 = 8'h00; r2 = 8'h00;
      bus_start();
      if (set_ptr) begin
         send_byte({DEV, 1'b0}, a); all_ack &= a;
         send_byte(instr, a); all_ack &= a;
         bus_start();
      end
      send_byte({DEV, 1'b1}, a); all_ack &= a;
      recv_byte(n > 1, r0);
      if (n > 1) recv_byte(n > 2, r1);
      if (n > 2) recv_byte(1'b0, r2);
      bus_stop();
   endtask

   function automatic logic [7:0] one(logic a);
      return {7'd0, a};
   endfunction

   task automatic t_reset();
      chk("R1 wiper", wiper, 8'h80);
      chk("R1 sda_oe", one(sda_oe), 8'h00);
      chk("R1 nv_req count", req_cnt[7:0], 8'h00);
   endtask

   task automatic t_rdac();
      logic ak; logic [7:0] r0, r1, r2;
      wr_txn(8'h00, 1, 8'h5A, 8'h00, ak);
      chk("R2 acks on write", one(ak), 8'h01);
      chk("R3 wiper after write", wiper, 8'h5A);
      rd_txn(1'b1, 8'h00, 1, r0, r1, r2, ak);
      chk("R4 rdac readback", r0, 8'h5A);
      chk("R2 acks on read", one(ak), 8'h01);
      chk("R4 released after NACK", one(sda_oe), 8'h00);
   endtask

   task automatic t_stream();
      logic a;
      bus_start();
      send_byte({DEV, 1'b0}, a);
      send_byte(8'h00, a);
      send_byte(8'h11, a);
      chk("R3 stream byte 1", wiper, 8'h11);
      send_byte(8'h33, a);
      chk("R3 stream byte 2", wiper, 8'h33);
      chk("R3 stream ack", one(a), 8'h01);
      bus_stop();
   endtask

   task automatic t_direct_read();
      logic ak; logic [7:0] r0, r1, r2;
      rd_txn(1'b0, 8'h00, 2, r0, r1, r2, ak);
      chk("R4 direct read 1", r0, 8'h33);
      chk("R4 repeated read 2", r1, 8'h33);
   endtask

   task automatic t_wrong_addr();
      logic a1, a2, a3;
      bus_start();
      send_byte({DEV ^ 7'h01, 1'b0}, a1);
      send_byte(8'h00, a2);
      send_byte(8'h77, a3);
      bus_stop();
      chk("R2 no ack foreign addr", one(a1 | a2 | a3), 8'h00);
      chk("R2 wiper untouched", wiper, 8'h33);
   endtask

   task automatic t_eep();
      logic ak; logic [7:0] r0, r1, r2;
      wr_txn(8'h20, 1, 8'hC3, 8'h00, ak);
      chk("R5 request count", req_cnt[7:0], 8'h01);
      chk("R5 request data", req_val, 8'hC3);
      rd_txn(1'b1, 8'h20, 1, r0, r1, r2, ak);
      chk("R5 mirror readback", r0, 8'hC3);
   endtask

   task automatic t_protect();
      logic ak; logic [7:0] r0, r1, r2;
      wr_txn(8'h40, 1, 8'h01, 8'h00, ak);
      rd_txn(1'b1, 8'h40, 1, r0, r1, r2, ak);
      chk("R6 protect readback set", r0, 8'h01);
      wr_txn(8'h20, 1, 8'h44, 8'h00, ak);
      chk("R7 protected write acked", one(ak), 8'h01);
      wr_txn(8'hC0, 0, 8'h00, 8'h00, ak);
      chk("R7 protected store acked", one(ak), 8'h01);
      chk("R7 no request", req_cnt[7:0], 8'h01);
      rd_txn(1'b1, 8'h20, 1, r0, r1, r2, ak);
      chk("R7 mirror unchanged", r0, 8'hC3);
      wr_txn(8'h40, 1, 8'hFE, 8'h00, ak);
      rd_txn(1'b1, 8'h40, 1, r0, r1, r2, ak);
      chk("R6 protect cleared by lsb", r0, 8'h00);
   endtask

   task automatic t_store_restore();
      logic ak; logic [7:0] r0, r1, r2;
      wr_txn(8'h00, 1, 8'h6B, 8'h00, ak);
      wr_txn(8'hC0, 0, 8'h00, 8'h00, ak);
      chk("R8 store request", req_cnt[7:0], 8'h02);
      chk("R8 store data", req_val, 8'h6B);
      rd_txn(1'b1, 8'h20, 1, r0, r1, r2, ak);
      chk("R8 mirror holds wiper", r0, 8'h6B);
      wr_txn(8'h00, 1, 8'h01, 8'h00, ak);
      wr_txn(8'hA0, 0, 8'h00, 8'h00, ak);
      chk("R8 restore to wiper", wiper, 8'h6B);
   endtask

   task automatic t_tolerance();
      logic ak; logic [7:0] r0, r1, r2;
      rd_txn(1'b1, 8'h3E, 3, r0, r1, r2, ak);
      chk("R9 tolerance integer", r0, 8'h1C);
      chk("R9 pointer advances", r1, 8'h0F);
      chk("R9 pointer holds", r2, 8'h0F);
      rd_txn(1'b1, 8'h3F, 1, r0, r1, r2, ak);
      chk("R9 fraction direct", r0, 8'h0F);
      wr_txn(8'h3E, 1, 8'h55, 8'h00, ak);
      chk("R10 tolerance write acked", one(ak), 8'h01);
      rd_txn(1'b1, 8'h3E, 1, r0, r1, r2, ak);
      chk("R10 tolerance unchanged", r0, 8'h1C);
   endtask

   task automatic t_busy();
      logic ak; logic [7:0] r0, r1, r2;
      wr_txn(8'h00, 1, 8'h20, 8'h00, ak);
      nv_busy = 1'b1;
      wr_txn(8'h20, 1, 8'h99, 8'h00, ak);
      chk("R11 busy write acked", one(ak), 8'h01);
      wr_txn(8'hA0, 0, 8'h00, 8'h00, ak);
      chk("R11 restore discarded", wiper, 8'h20);
      wr_txn(8'hC0, 0, 8'h00, 8'h00, ak);
      chk("R11 no request", req_cnt[7:0], 8'h02);
      nv_busy = 1'b0;
      rd_txn(1'b1, 8'h20, 1, r0, r1, r2, ak);
      chk("R11 mirror unchanged", r0, 8'h6B);
   endtask

   initial begin
      tick(5);
      t_reset();
      rst_n = 1'b1;
      tick(5);
      t_reset();
      t_rdac();
      t_stream();
      t_direct_read();
      t_wrong_addr();
      t_eep();
      t_protect();
      t_store_restore();
      t_tolerance();
      t_busy();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule